// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block is the one-level direction predictor of a simple pipelined CPU. Each table entry holds a small saturating counter, a flag that marks the entry as belonging to a conditional branch, and the branch's last resolved target. In the fetch stage the pipeline gives a fetch PC. One clock later the block returns a predicted direction, a predicted target, the is-branch flag, and a copy of the counter it read. The pipeline carries that counter copy with the instruction.

When the instruction resolves, the pipeline returns the resolve PC, the real outcome, the real target, the is-branch flag and the carried counter copy. The new counter is computed from the carried copy and not from a second table read, so the table needs only one read port and one write port. The table is addressed by a field of the PC that skips the two alignment bits. The index width is a parameter: 14 bits gives the full 16K-entry table, and the default is smaller.

Top module: `bimodal_dir_predictor`

## Requirements
- R1: After reset, every lookup returns counter 0, direction not taken, is-branch 0 and target 0 until that entry is written.
- R2: A lookup issued with `fetch_valid` high at a clock edge shows its result on the prediction outputs after that edge. `pred_valid` equals the `fetch_valid` of the previous cycle.
- R3: A branch that resolves taken writes back the carried counter plus one. A carried value of 3 writes back 3.
- R4: A branch that resolves not taken writes back the carried counter minus one. A carried value of 0 writes back 0.
- R5: `pred_taken` is 1 exactly when the returned 2-bit counter is 2 or 3, which means its most significant bit is set.
- R6: The entry index is PC bits [IDX_LO+IDX_W-1:IDX_LO] (bits 11:2 by default). PCs that differ only in bits 1:0 or only above the index field select the same entry.
- R7: A written entry returns is-branch 1 and the resolve target with bits 1:0 forced to zero.
- R8: The written counter is derived from `upd_ctr`. The counter already stored in the entry has no influence on it.
- R9: Nothing is written unless `upd_valid` and `upd_is_branch` are both 1.
- R10: When a lookup and an update hit the same index in the same cycle, the lookup returns the contents from before the update.
- R11: A fresh entry trained on the repeating outcome pattern taken, taken, taken, not-taken predicts not, not, taken, taken, taken, taken and so on. After warm-up, 3 of every 4 predictions are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_pc | input | PC_W | PC of the instruction being fetched |
| pred_valid | output | 1 | Prediction outputs hold a lookup result |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_target | output | PC_W | Predicted target address |
| pred_is_branch | output | 1 | Entry marks a conditional branch |
| pred_ctr | output | CTR_W | Counter snapshot to carry down the pipe |
| upd_valid | input | 1 | Resolve information present this cycle |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_is_branch | input | 1 | Resolved instruction is a conditional branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | PC_W | Actual branch target |
| upd_ctr | input | CTR_W | Counter snapshot carried from prediction |

## Verification
Two cases are the hardest to reach from the ports. The first is a lookup and an update landing on the same entry in the same cycle. The second is a carried counter that no longer matches the stored one. A uniformly random PC across the table almost never produces either. The random phase therefore draws the index from only sixteen entries and randomises the bits outside the index field, so aliasing, same-cycle collisions and read-after-write sequences occur constantly. About a quarter of the updates carry a random counter snapshot instead of the value last returned, which exercises R8 throughout the run. Directed sequences pin down the saturation limits and the taken/not-taken training pattern.

// File: rtl/bp_pkg.sv
package bp_pkg;

  parameter int unsigned BP_PC_W_DEF  = 32;
  parameter int unsigned BP_CTR_W_DEF = 2;

  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_DEC  = 2'd2
  } ctr_action_e;

endpackage

// File: rtl/bp_index_slice.sv
module bp_index_slice #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_LO = 2,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

  assign idx = pc[IDX_HI:IDX_LO];

  // bits outside the index field only alias entries
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:IDX_HI+1], pc[IDX_LO-1:0]};

endmodule

// File: rtl/bp_sat_update.sv
module bp_sat_update
  import bp_pkg::*;
#(
  parameter int unsigned CTR_W = 2
) (
  input  logic [CTR_W-1:0] ctr_in,
  input  logic             taken,
  output logic [CTR_W-1:0] ctr_out
);

  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  ctr_action_e act;

  always_comb begin
    if (taken) begin
      act = (ctr_in == CTR_MAX) ? CTR_HOLD : CTR_INC;
    end else begin
      act = (ctr_in == CTR_MIN) ? CTR_HOLD : CTR_DEC;
    end
  end

  always_comb begin
    unique case (act)
      CTR_INC: ctr_out = ctr_in + CTR_W'(1);
      CTR_DEC: ctr_out = ctr_in - CTR_W'(1);
      default: ctr_out = ctr_in;
    endcase
  end

endmodule

// File: rtl/bp_entry_ram.sv
module bp_entry_ram #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 33
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first: a same-address write lands after the read samples
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/bp_valid_bits.sv
module bp_valid_bits #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_vld,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
    end else if (rd_en) begin
      rd_vld <= vld_q[rd_addr];
    end
  end

endmodule

// File: rtl/bimodal_dir_predictor.sv
module bimodal_dir_predictor
  import bp_pkg::*;
#(
  parameter int unsigned PC_W   = BP_PC_W_DEF,
  parameter int unsigned CTR_W  = BP_CTR_W_DEF,
  parameter int unsigned IDX_LO = 2,
  parameter int unsigned IDX_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_target,
  output logic             pred_is_branch,
  output logic [CTR_W-1:0] pred_ctr,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_is_branch,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  input  logic [CTR_W-1:0] upd_ctr
);

  localparam int unsigned TGT_W  = PC_W - IDX_LO;
  localparam int unsigned DATA_W = CTR_W + 1 + TGT_W;

  typedef struct packed {
    logic [CTR_W-1:0] ctr;
    logic             is_br;
    logic [TGT_W-1:0] tgt;
  } entry_t;

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             tbl_wr_en;
  logic [CTR_W-1:0] wr_ctr;
  entry_t           wr_entry;
  entry_t           rd_entry;
  logic             rd_vld;
  logic             rd_en;

  bp_index_slice #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_rd_slice (
    .pc  (fetch_pc),
    .idx (rd_idx)
  );

  bp_index_slice #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_wr_slice (
    .pc  (upd_pc),
    .idx (wr_idx)
  );

  bp_sat_update #(.CTR_W(CTR_W)) u_sat (
    .ctr_in  (upd_ctr),
    .taken   (upd_taken),
    .ctr_out (wr_ctr)
  );

  assign tbl_wr_en = upd_valid & upd_is_branch & ~rst;
  assign rd_en     = fetch_valid & ~rst;

  assign wr_entry.ctr   = wr_ctr;
  assign wr_entry.is_br = upd_is_branch;
  assign wr_entry.tgt   = upd_target[PC_W-1:IDX_LO];

  logic unused_tgt_bits;
  assign unused_tgt_bits = ^upd_target[IDX_LO-1:0];

  bp_entry_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_addr (rd_idx),
    .rd_data (rd_entry),
    .wr_en   (tbl_wr_en),
    .wr_addr (wr_idx),
    .wr_data (wr_entry)
  );

  bp_valid_bits #(.IDX_W(IDX_W)) u_vld (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_idx),
    .rd_vld  (rd_vld),
    .wr_en   (tbl_wr_en),
    .wr_addr (wr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
    end else begin
      pred_valid <= fetch_valid;
    end
  end

  // an entry never written reads as a cleared one
  always_comb begin
    if (rd_vld) begin
      pred_ctr       = rd_entry.ctr;
      pred_is_branch = rd_entry.is_br;
      pred_target    = {rd_entry.tgt, {IDX_LO{1'b0}}};
    end else begin
      pred_ctr       = '0;
      pred_is_branch = 1'b0;
      pred_target    = '0;
    end
    pred_taken = rd_vld & rd_entry.ctr[CTR_W-1];
  end

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CTR_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_valid,
  input logic             pred_valid,
  input logic             pred_taken,
  input logic [PC_W-1:0]  pred_target,
  input logic             pred_is_branch,
  input logic [CTR_W-1:0] pred_ctr,
  input logic             upd_valid,
  input logic             upd_is_branch,
  input logic             upd_taken,
  input logic [CTR_W-1:0] upd_ctr,
  input logic             wr_en,
  input logic [CTR_W-1:0] wr_ctr
);

  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);

  a_r5_taken_msb: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_taken == pred_ctr[CTR_W-1]));

  a_r7_target_aligned: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_target[1:0] == 2'b00));

  a_r1_cleared_entry: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_is_branch) |-> (pred_ctr == '0 && !pred_taken));

  a_r3_inc_sat: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_is_branch && upd_taken) |->
      (wr_en && wr_ctr == ((upd_ctr == CMAX) ? CMAX : upd_ctr + CTR_W'(1))));

  a_r4_dec_sat: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_is_branch && !upd_taken) |->
      (wr_en && wr_ctr == ((upd_ctr == '0) ? '0 : upd_ctr - CTR_W'(1))));

  a_r9_no_write: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && upd_is_branch) |-> !wr_en);

endmodule

bind bimodal_dir_predictor bp_checker #(.PC_W(PC_W), .CTR_W(CTR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fetch_valid    (fetch_valid),
  .pred_valid     (pred_valid),
  .pred_taken     (pred_taken),
  .pred_target    (pred_target),
  .pred_is_branch (pred_is_branch),
  .pred_ctr       (pred_ctr),
  .upd_valid      (upd_valid),
  .upd_is_branch  (upd_is_branch),
  .upd_taken      (upd_taken),
  .upd_ctr        (upd_ctr),
  .wr_en          (tbl_wr_en),
  .wr_ctr         (wr_ctr)
);

// File: tb/test_bimodal_dir_predictor.sv
`timescale 1ns/1ps
module test_bimodal_dir_predictor;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_valid, pred_taken, pred_is_branch;
  logic [31:0] pred_target;
  logic [1:0]  pred_ctr;
  logic        upd_valid = 1'b0, upd_is_branch = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic [1:0]  upd_ctr = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]  r_ctr [DEPTH];
  logic        r_vld [DEPTH];
  logic [31:0] r_tgt [DEPTH];

  always #5 clk = ~clk;

  bimodal_dir_predictor i_bimodal_dir_predictor (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_is_branch(pred_is_branch), .pred_ctr(pred_ctr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_branch(upd_is_branch),
    .upd_taken(upd_taken), .upd_target(upd_target), .upd_ctr(upd_ctr)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) & 32'(DEPTH - 1));
  endfunction

  function automatic logic [1:0] sat_next(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%s exp=%s", tag, got, exp);
    end
  endtask

  // one clock: drive, compute expectation from old model state, update model, sample
  task automatic step(input bit fv, input logic [31:0] fpc,
                      input bit uv, input bit ub, input bit ut,
                      input logic [31:0] upc, input logic [31:0] utg,
                      input logic [1:0] uc, input string tag);
    logic [1:0]  e_ctr;
    logic        e_br, e_tk;
    logic [31:0] e_tg;
    int fi, ui;
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_is_branch = ub; upd_taken = ut;
    upd_pc = upc; upd_target = utg; upd_ctr = uc;
    fi = idx_of(fpc);
    e_ctr = r_vld[fi] ? r_ctr[fi] : 2'd0;
    e_br  = r_vld[fi];
    e_tg  = r_vld[fi] ? r_tgt[fi] : 32'd0;
    e_tk  = e_ctr[1];
    if (uv && ub) begin
      ui = idx_of(upc);
      r_vld[ui] = 1'b1;
      r_ctr[ui] = sat_next(uc, ut);
      r_tgt[ui] = {utg[31:2], 2'b00};
    end
    @(posedge clk);
    #1;
    check(pred_valid == fv, {tag, " R2 valid"},
          $sformatf("%0b", pred_valid), $sformatf("%0b", fv));
    if (fv) begin
      check({pred_taken, pred_ctr, pred_is_branch, pred_target} == {e_tk, e_ctr, e_br, e_tg},
            tag,
            $sformatf("tk=%0b ctr=%0d br=%0b tgt=%h", pred_taken, pred_ctr, pred_is_branch, pred_target),
            $sformatf("tk=%0b ctr=%0d br=%0b tgt=%h", e_tk, e_ctr, e_br, e_tg));
    end
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    step(1'b1, pc, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 2'd0, tag);
  endtask

  task automatic train(input logic [31:0] pc, input bit t, input logic [31:0] tg,
                       input logic [1:0] c, input string tag);
    step(1'b0, 32'd0, 1'b1, 1'b1, t, pc, tg, c, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'd4720);
    for (int i = 0; i < DEPTH; i++) begin
      r_vld[i] = 1'b0; r_ctr[i] = 2'd0; r_tgt[i] = 32'd0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state at several entries
    look(32'h0000_0000, "R1 reset idx0");
    look(32'h0000_0ffc, "R1 reset last");
    look(32'h1234_5678, "R1 reset mid");

    // R3 / R7: taken from carried 0, then saturation at 3
    train(32'h0000_0100, 1'b1, 32'hdead_beef, 2'd0, "R3 inc");
    look(32'h0000_0100, "R3 inc R7 target");
    train(32'h0000_0100, 1'b1, 32'hdead_beef, 2'd3, "R3 sat");
    look(32'h0000_0100, "R3 sat at 3 R5 taken");
    // R4: not taken, and floor at 0
    train(32'h0000_0104, 1'b0, 32'h0000_0040, 2'd2, "R4 dec");
    look(32'h0000_0104, "R4 dec to 1 R5 not taken");
    train(32'h0000_0104, 1'b0, 32'h0000_0040, 2'd0, "R4 floor");
    look(32'h0000_0104, "R4 floor at 0");

    // R8: stored counter is 1, carried snapshot 3 not taken -> 2
    train(32'h0000_0108, 1'b1, 32'h0000_0080, 2'd0, "R8 setup");
    train(32'h0000_0108, 1'b0, 32'h0000_0080, 2'd3, "R8 carried");
    look(32'h0000_0108, "R8 carried snapshot wins");

    // R6: aliasing through high bits and alignment bits
    train(32'h0000_0110, 1'b1, 32'h0000_1000, 2'd2, "R6 setup");
    look(32'h5555_1113, "R6 alias high+low bits");

    // R9: non-branch update and invalid update change nothing
    step(1'b0, 32'd0, 1'b1, 1'b0, 1'b1, 32'h0000_0200, 32'h1111_1110, 2'd3, "R9 not branch");
    look(32'h0000_0200, "R9 not-branch left entry clear");
    step(1'b0, 32'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0204, 32'h1111_1110, 2'd3, "R9 not valid");
    look(32'h0000_0204, "R9 invalid left entry clear");

    // R10: same-cycle read and write to one index
    step(1'b1, 32'h0000_0300, 1'b1, 1'b1, 1'b1, 32'h0000_0300, 32'h0000_abc0, 2'd2, "R10 fresh collide");
    look(32'h0000_0300, "R10 after write");
    step(1'b1, 32'h0000_0300, 1'b1, 1'b1, 1'b0, 32'h0000_0300, 32'h0000_abc0, 2'd0, "R10 old value");

    // R11: TTTN from a fresh entry, counter carried from each prediction
    begin
      int correct = 0;
      bit pred_seq [16];
      for (int i = 0; i < 16; i++) begin
        logic [1:0] snap;
        bit outc;
        outc = (i % 4) != 3;
        look(32'h0000_04b0, "R11 lookup");
        snap = pred_ctr;
        pred_seq[i] = pred_taken;
        if (i >= 4 && pred_taken == outc) correct++;
        train(32'h0000_04b0, outc, 32'h0000_0400, snap, "R11 train");
      end
      check(pred_seq[0] == 1'b0 && pred_seq[1] == 1'b0 && pred_seq[2] == 1'b1 && pred_seq[3] == 1'b1,
            "R11 warm-up n n t t", $sformatf("%0b%0b%0b%0b", pred_seq[0], pred_seq[1], pred_seq[2], pred_seq[3]), "0011");
      check(correct == 9, "R11 steady accuracy 3/4", $sformatf("%0d", correct), "9");
    end

    // random phase: few indices, random alias bits, some stale snapshots
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fpc, upc, utg;
      logic [1:0]  uc;
      bit fv, uv, ub, ut;
      fpc = {$urandom_range(0, 1) ? 20'($urandom) : 20'd0, 6'd0, 4'($urandom_range(0, 15)), 2'($urandom)};
      upc = {20'($urandom), 6'd0, 4'($urandom_range(0, 15)), 2'($urandom)};
      if ($urandom_range(0, 3) == 0) upc = fpc;
      utg = $urandom;
      fv = $urandom_range(0, 3) != 0;
      uv = $urandom_range(0, 3) != 0;
      ub = $urandom_range(0, 4) != 0;
      ut = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) uc = 2'($urandom);
      else uc = r_vld[idx_of(upc)] ? r_ctr[idx_of(upc)] : 2'd0;
      step(fv, fpc, uv, ub, ut, upc, utg, uc, "R2/R5/R6/R8/R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule